// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Rounding Control

This block multiplies two 32-bit operands and adds the product into a 48-bit accumulator, or takes it away from the accumulator. A three-bit mode register selects how the product is formed and how the accumulator is read back. In fractional mode both operands are signed fractions. The 64-bit product is shifted left one place to align the binary point, then cut down to its upper 40 bits. The cut either truncates or rounds to nearest, with ties going to the even value. The eight bits above the reduced product are sign-extended guard bits.

The store path reads the accumulator back as a fraction. With the narrow bit clear, the result is a 32-bit fraction, either truncated or rounded on the low 8 accumulator bits. With the narrow bit set, the result is a 16-bit fraction that is always rounded on the low 24 bits. In integer mode the product is neither shifted nor rounded, and the narrow bit selects unsigned operands. Each accumulate takes effect on the clock edge that samples its valid strobe. The mode used for an operation is the mode held in the register during that cycle.

Top module: `fmac_round_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator and all three mode bits to zero.
- R2: When `mode_we` is high at a rising edge, `mode_in` is loaded into the mode register. Bit 0 is round (1 = round, 0 = truncate), bit 1 is fractional (1 = fractional, 0 = integer) and bit 2 is narrow/unsigned. The register otherwise holds its value.
- R3: In fractional mode the signed 64-bit product is shifted left by one bit. Its upper 40 bits become the addend, sign-extended to 48 bits. With the round bit 0, the lower 24 bits are dropped without rounding.
- R4: In fractional mode with the round bit 1, the product is reduced by round-to-nearest-even on the 24 dropped bits. Above one half rounds up, below one half truncates, and exactly one half rounds up only when the kept lsb is 1. The carry ripples through all 40 kept bits.
- R5: When `op_valid` is high at a rising edge, the accumulator becomes accumulator + addend if `op_sub` is 0, or accumulator − addend if `op_sub` is 1, modulo 2^48. Both forms use the same product reduction.
- R6: When `op_valid` is low and reset is not asserted, the accumulator keeps its value.
- R7: In fractional mode with the narrow bit 0 and the round bit 0, `store_data` equals accumulator bits 39..8.
- R8: In fractional mode with the narrow bit 0 and the round bit 1, `store_data` is accumulator bits 39..8 rounded to nearest-even on bits 7..0, modulo 2^32.
- R9: In fractional mode with the narrow bit 1, `store_data[31:16]` is accumulator bits 39..24 rounded to nearest-even on bits 23..0, modulo 2^16, whatever the round bit. `store_data[15:0]` is zero.
- R10: In integer mode the product is neither shifted nor rounded. It is signed when the narrow bit is 0 and unsigned when it is 1, and its low 48 bits form the addend. `store_data` equals accumulator bits 31..0.
- R11: An operation presented in the same cycle as a mode write uses the mode held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Loads `mode_in` into the mode register |
| mode_in | input | 3 | New mode: {narrow, fractional, round} |
| op_valid | input | 1 | Operand strobe, one operation per high cycle |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_q | output | 48 | Accumulator contents |
| mode_q | output | 3 | Current mode register |
| store_data | output | 32 | Accumulator read back as fraction or integer per mode |

## Verification
The assertions check several properties on every cycle. Every rounder changes its truncated value by at most one, and only when rounding is enabled. Every exact-half tie gives an even result. The accumulator holds whenever no operand is strobed, and reset and mode loads land on the following edge. Whether the reduced product has the right alignment and sign, whether subtraction uses the same reduction, and whether each store width picks the right bits can only be shown by the bench's scenarios. These are hand-picked ties just above and below one half, negative products, mode writes that collide with operations, and a long random mix, all compared with a behavioural model.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
   // Mode register layout: bit 2 narrow/unsigned, bit 1 fractional, bit 0 round
   typedef struct packed {
      logic narrow;
      logic frac;
      logic rnd;
   } fmac_mode_t;

   localparam int MODE_W = 3;
endpackage

// File: rtl/fmac_rne.sv
// Drops DROP_W low bits of a value, optionally rounding to nearest-even.
module fmac_rne #(
   parameter int IN_W   = 64,
   parameter int DROP_W = 24
) (
   input  logic [IN_W-1:0]        val,
   input  logic                   en,
   output logic [IN_W-DROP_W-1:0] res
);
   localparam int KEEP_W = IN_W - DROP_W;
   localparam logic [DROP_W-1:0] HALF = DROP_W'(1) << (DROP_W - 1);

   initial begin
      assert (DROP_W >= 1 && DROP_W < IN_W)
         else $error("fmac_rne: DROP_W must lie in 1..IN_W-1");
   end

   logic [KEEP_W-1:0] kept;
   logic [DROP_W-1:0] rem;
   logic              above, tie, bump;

   assign kept  = val[IN_W-1:DROP_W];
   assign rem   = val[DROP_W-1:0];
   assign above = rem > HALF;
   assign tie   = rem == HALF;
   assign bump  = en && (above || (tie && kept[0]));
   assign res   = kept + KEEP_W'(bump);

   logic [KEEP_W-1:0] delta;
   assign delta = res - kept;

   always_comb begin
      // R4: rounding moves the kept part by at most one, never when disabled
      assert_step_R4: assert ((delta == '0) || (en && delta == KEEP_W'(1)))
         else $error("rounder step out of range");
      // R4: an exact half always yields an even result when rounding
      assert_tie_even_R4: assert (!(en && tie) || !res[0])
         else $error("tie not rounded to even");
   end
endmodule

// File: rtl/fmac_product.sv
// Forms the addend from two operands according to the mode.
module fmac_product
   import fmac_pkg::*;
#(
   parameter int OP_W  = 32,
   parameter int RED_W = 40,
   parameter int ACC_W = 48
) (
   input  logic [OP_W-1:0]  a,
   input  logic [OP_W-1:0]  b,
   input  fmac_mode_t       mode,
   output logic [ACC_W-1:0] addend
);
   localparam int PROD_W = 2 * OP_W;
   localparam int DROP_W = PROD_W - RED_W;
   localparam int GUARD  = ACC_W - RED_W;
   localparam int IEXT   = ACC_W - OP_W;

   initial begin
      assert (RED_W < PROD_W && RED_W > OP_W)
         else $error("fmac_product: RED_W must lie between OP_W and 2*OP_W");
      assert (ACC_W >= RED_W && ACC_W <= PROD_W)
         else $error("fmac_product: ACC_W must lie in RED_W..2*OP_W");
   end

   // Fractional path: full signed product, binary point aligned
   logic [PROD_W-1:0] sa_w, sb_w, sprod, aligned;
   logic [RED_W-1:0]  reduced;
   logic [ACC_W-1:0]  frac_add;

   assign sa_w    = {{OP_W{a[OP_W-1]}}, a};
   assign sb_w    = {{OP_W{b[OP_W-1]}}, b};
   assign sprod   = sa_w * sb_w;
   assign aligned = sprod << 1;

   fmac_rne #(.IN_W(PROD_W), .DROP_W(DROP_W)) u_prod_rne (
      .val (aligned),
      .en  (mode.rnd),
      .res (reduced)
   );

   generate
      if (GUARD > 0) begin : g_guard
         assign frac_add = {{GUARD{reduced[RED_W-1]}}, reduced};
      end else begin : g_noguard
         assign frac_add = reduced;
      end
   endgenerate

   // Integer path: product computed directly at accumulator width
   logic [ACC_W-1:0] ia_s, ib_s, ia_u, ib_u, int_add;

   generate
      if (IEXT > 0) begin : g_iext
         assign ia_s = {{IEXT{a[OP_W-1]}}, a};
         assign ib_s = {{IEXT{b[OP_W-1]}}, b};
         assign ia_u = {{IEXT{1'b0}}, a};
         assign ib_u = {{IEXT{1'b0}}, b};
      end else begin : g_inoext
         assign ia_s = a;
         assign ib_s = b;
         assign ia_u = a;
         assign ib_u = b;
      end
   endgenerate

   assign int_add = mode.narrow ? (ia_u * ib_u) : (ia_s * ib_s);
   assign addend  = mode.frac ? frac_add : int_add;
endmodule

// File: rtl/fmac_acc.sv
// Accumulator register with add/subtract step.
module fmac_acc #(
   parameter int ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid,
   input  logic             sub,
   input  logic [ACC_W-1:0] addend,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] sum, dif;

   assign sum = acc + addend;
   assign dif = acc - addend;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (valid) begin
         acc <= sub ? dif : sum;
      end
   end

   // R1: reset leaves the accumulator empty
   assert_acc_reset_R1: assert property (@(posedge clk) rst |=> acc == '0)
      else $error("accumulator not cleared by reset");

   // R6: no strobe, no change
   assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !valid |=> $stable(acc))
      else $error("accumulator changed without a strobe");
endmodule

// File: rtl/fmac_store.sv
// Reads the accumulator back as a wide or narrow fraction, or as an integer.
module fmac_store
   import fmac_pkg::*;
#(
   parameter int RED_W    = 40,
   parameter int OUT_W    = 32,
   parameter int NARROW_W = 16
) (
   input  logic [RED_W-1:0] acc_lo,
   input  fmac_mode_t       mode,
   output logic [OUT_W-1:0] store
);
   localparam int WIDE_DROP   = RED_W - OUT_W;
   localparam int NARROW_DROP = RED_W - NARROW_W;
   localparam int PAD_W       = OUT_W - NARROW_W;

   initial begin
      assert (NARROW_W < OUT_W && OUT_W < RED_W)
         else $error("fmac_store: need NARROW_W < OUT_W < RED_W");
   end

   logic [OUT_W-1:0]    wide_res;
   logic [NARROW_W-1:0] narrow_res;
   logic [OUT_W-1:0]    narrow_word;

   fmac_rne #(.IN_W(RED_W), .DROP_W(WIDE_DROP)) u_wide_rne (
      .val (acc_lo),
      .en  (mode.rnd),
      .res (wide_res)
   );

   fmac_rne #(.IN_W(RED_W), .DROP_W(NARROW_DROP)) u_narrow_rne (
      .val (acc_lo),
      .en  (1'b1),
      .res (narrow_res)
   );

   assign narrow_word = {narrow_res, {PAD_W{1'b0}}};

   always_comb begin
      if (!mode.frac)       store = acc_lo[OUT_W-1:0];
      else if (mode.narrow) store = narrow_word;
      else                  store = wide_res;
   end
endmodule

// File: rtl/fmac_round_unit.sv
module fmac_round_unit
   import fmac_pkg::*;
#(
   parameter int OP_W     = 32,
   parameter int ACC_W    = 48,
   parameter int RED_W    = 40,
   parameter int NARROW_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_we,
   input  logic [2:0]        mode_in,
   input  logic              op_valid,
   input  logic              op_sub,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [ACC_W-1:0]  acc_q,
   output logic [2:0]        mode_q,
   output logic [OP_W-1:0]   store_data
);
   initial begin
      assert (MODE_W == 3) else $error("mode width mismatch");
   end

   fmac_mode_t       mode_r;
   logic [ACC_W-1:0] addend;

   always_ff @(posedge clk) begin
      if (rst)          mode_r <= '0;
      else if (mode_we) mode_r <= fmac_mode_t'(mode_in);
   end

   assign mode_q = mode_r;

   fmac_product #(.OP_W(OP_W), .RED_W(RED_W), .ACC_W(ACC_W)) u_product (
      .a      (op_a),
      .b      (op_b),
      .mode   (mode_r),
      .addend (addend)
   );

   fmac_acc #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .valid  (op_valid),
      .sub    (op_sub),
      .addend (addend),
      .acc    (acc_q)
   );

   fmac_store #(.RED_W(RED_W), .OUT_W(OP_W), .NARROW_W(NARROW_W)) u_store (
      .acc_lo (acc_q[RED_W-1:0]),
      .mode   (mode_r),
      .store  (store_data)
   );

   // R1: reset clears the mode
   assert_mode_reset_R1: assert property (@(posedge clk) rst |=> mode_q == '0)
      else $error("mode not cleared by reset");

   // R2: a write lands on the next edge
   assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
      mode_we |=> mode_q == $past(mode_in))
      else $error("mode write lost");

   // R2: without a write the mode holds
   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !mode_we |=> $stable(mode_q))
      else $error("mode changed without a write");
endmodule

// File: tb/tb_fmac_round_unit.sv
`timescale 1ns/1ps
module tb_fmac_round_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_we = 1'b0;
   logic [2:0]  mode_in = '0;
   logic        op_valid = 1'b0;
   logic        op_sub = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [47:0] acc_q;
   logic [2:0]  mode_q;
   logic [31:0] store_data;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   always #2 clk = ~clk;

   fmac_round_unit dut (
      .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in),
      .op_valid(op_valid), .op_sub(op_sub), .op_a(op_a), .op_b(op_b),
      .acc_q(acc_q), .mode_q(mode_q), .store_data(store_data)
   );

   function automatic logic [63:0] near_even(logic [63:0] v, int drop);
      logic [63:0] k, r, h;
      k = v >> drop;
      r = v & ((64'd1 << drop) - 64'd1);
      h = 64'd1 << (drop - 1);
      if (r > h || (r == h && k[0])) k = k + 64'd1;
      return k;
   endfunction

   // Behavioural reference
   logic [47:0] m_acc  = '0;
   logic [2:0]  m_mode = '0;

   function automatic logic [47:0] model_addend(logic [2:0] md, logic [31:0] a, logic [31:0] b);
      longint      sp;
      logic [63:0] p2, up;
      logic [39:0] r40;
      if (md[1]) begin
         sp = longint'(signed'(a)) * longint'(signed'(b));
         p2 = 64'(sp) << 1;
         r40 = md[0] ? near_even(p2, 24) : (p2 >> 24);
         return {{8{r40[39]}}, r40};
      end else if (md[2]) begin
         up = {32'd0, a} * {32'd0, b};
         return up[47:0];
      end else begin
         sp = longint'(signed'(a)) * longint'(signed'(b));
         return 48'(sp);
      end
   endfunction

   function automatic logic [31:0] model_store(logic [2:0] md, logic [47:0] acc);
      logic [63:0] v;
      v = {24'd0, acc[39:0]};
      if (!md[1]) return acc[31:0];
      if (md[2])  return {16'(near_even(v, 24)), 16'h0000};
      if (md[0])  return 32'(near_even(v, 8));
      return acc[39:8];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_acc  = '0;
         m_mode = '0;
      end else begin
         if (op_valid)
            m_acc = op_sub ? m_acc - model_addend(m_mode, op_a, op_b)
                           : m_acc + model_addend(m_mode, op_a, op_b);
         if (mode_we) m_mode = mode_in;
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, after outputs settle
   always @(posedge clk) begin
      #1;
      if (!finished) begin
         chk({cur_req, " acc"},   64'(acc_q),      64'(m_acc));
         chk({cur_req, " mode"},  64'(mode_q),     64'(m_mode));
         chk({cur_req, " store"}, 64'(store_data), 64'(model_store(m_mode, m_acc)));
      end
   end

   task automatic pulse_rst();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic set_mode(logic [2:0] m);
      @(negedge clk); mode_we = 1'b1; mode_in = m;
      @(negedge clk); mode_we = 1'b0;
   endtask

   task automatic do_op(logic [31:0] a, logic [31:0] b, logic s);
      @(negedge clk); op_valid = 1'b1; op_a = a; op_b = b; op_sub = s;
      @(negedge clk); op_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 acc after reset", 64'(acc_q), 64'h0);
      chk("R1 mode after reset", 64'(mode_q), 64'h0);

      cur_req = "R2";
      set_mode(3'b011);
      chk("R2 mode load", 64'(mode_q), 64'h3);

      cur_req = "R4";
      do_op(32'h1, 32'h00C0_0000, 1'b0);
      chk("R4 tie odd rounds up", 64'(acc_q), 64'h2);
      pulse_rst(); set_mode(3'b011);
      do_op(32'h1, 32'h0040_0000, 1'b0);
      chk("R4 tie even stays", 64'(acc_q), 64'h0);
      do_op(32'h1, 32'h0040_0001, 1'b0);
      chk("R4 above half", 64'(acc_q), 64'h1);
      pulse_rst(); set_mode(3'b011);
      do_op(32'h1, 32'h003F_FFFF, 1'b0);
      chk("R4 below half", 64'(acc_q), 64'h0);
      do_op(32'hFFFF_FFFF, 32'h00C0_0000, 1'b0);
      chk("R4 negative tie", 64'(acc_q), 64'hFFFF_FFFF_FFFE);

      cur_req = "R5";
      pulse_rst(); set_mode(3'b011);
      do_op(32'h1, 32'h00C0_0000, 1'b1);
      chk("R5 subtract rounded", 64'(acc_q), 64'hFFFF_FFFF_FFFE);

      cur_req = "R3";
      pulse_rst(); set_mode(3'b010);
      do_op(32'h1, 32'h00C0_0000, 1'b0);
      chk("R3 truncated product", 64'(acc_q), 64'h1);
      do_op(32'h4000_0000, 32'h4000_0000, 1'b0);
      chk("R3 quarter", 64'(acc_q), 64'h20_0000_0001);

      cur_req = "R6";
      repeat (5) @(negedge clk);
      chk("R6 idle hold", 64'(acc_q), 64'h20_0000_0001);

      cur_req = "R10";
      pulse_rst(); set_mode(3'b000);
      do_op(32'h180, 32'h1, 1'b0);
      chk("R10 integer store", 64'(store_data), 64'h180);
      cur_req = "R8";
      set_mode(3'b011);
      chk("R8 store tie odd", 64'(store_data), 64'h2);
      cur_req = "R7";
      set_mode(3'b010);
      chk("R7 store truncate", 64'(store_data), 64'h1);
      cur_req = "R8";
      pulse_rst(); set_mode(3'b000);
      do_op(32'h80, 32'h1, 1'b0);
      set_mode(3'b011);
      chk("R8 store tie even", 64'(store_data), 64'h0);

      cur_req = "R9";
      pulse_rst(); set_mode(3'b000);
      do_op(32'h0180_0000, 32'h1, 1'b0);
      set_mode(3'b110);
      chk("R9 narrow store", 64'(store_data), 64'h0002_0000);
      set_mode(3'b111);
      chk("R9 narrow ignores round bit", 64'(store_data), 64'h0002_0000);

      cur_req = "R10";
      pulse_rst(); set_mode(3'b100);
      do_op(32'hFFFF_FFFF, 32'h2, 1'b0);
      chk("R10 unsigned product", 64'(acc_q), 64'h1_FFFF_FFFE);
      pulse_rst(); set_mode(3'b000);
      do_op(32'hFFFF_FFFF, 32'h2, 1'b0);
      chk("R10 signed product", 64'(acc_q), 64'hFFFF_FFFF_FFFE);

      cur_req = "R11";
      pulse_rst(); set_mode(3'b000);
      @(negedge clk);
      mode_we = 1'b1; mode_in = 3'b010;
      op_valid = 1'b1; op_a = 32'h1; op_b = 32'h1; op_sub = 1'b0;
      @(negedge clk);
      mode_we = 1'b0; op_valid = 1'b0;
      chk("R11 old mode used", 64'(acc_q), 64'h1);
      chk("R11 new mode loaded", 64'(mode_q), 64'h2);

      cur_req = "R5 random";
      pulse_rst();
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         mode_we  = ($urandom % 8) == 0;
         mode_in  = 3'($urandom);
         op_valid = ($urandom % 4) != 0;
         op_sub   = 1'($urandom);
         op_a     = (i % 3 == 0) ? {8'h00, 24'($urandom)} : $urandom;
         op_b     = (i % 5 == 0) ? 32'h00C0_0000 : $urandom;
      end
      @(negedge clk);
      mode_we = 1'b0; op_valid = 1'b0;
      repeat (2) @(negedge clk);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule